// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fixed 50 MHz reference clock into a one-cycle enable pulse for a UART. The pulse runs at sixteen times the chosen line rate, which is the usual oversampling rate. A 16-bit phase accumulator sets the rate instead of a terminal-count divider. On every clock edge the accumulator adds an increment word to itself, and the carry out of that addition becomes the tick. The tick rate is therefore clk × inc / 65536. Line rates that do not divide the clock evenly come out with only a small fractional error. The error is spread evenly over time instead of building up.

The increment comes from one of two places. The first is a small preset table indexed by a 2-bit rate select, which covers 115200, 230400, 460800 and 921600 baud. The second is a free increment word that the surrounding logic chooses with an override enable. The accumulator keeps its remainder when the increment changes, so a rate switch takes effect on the next edge without a phase restart. The baud logic is meant to run from the 50 MHz reference and not from a faster processor clock.

Top module: `baud_tick_gen`

## Requirements
- R1: `rst` is synchronous and active high. After any clock edge that sees `rst` high, `tick_o` is low and the accumulator holds zero. After release, counting restarts from zero.
- R2: `tick_o` is registered. It is high for exactly one cycle after each edge whose 16-bit addition carries out. Over the first W cycles after reset release with a constant increment, the bench sees floor(W × inc / 65536) ticks.
- R3: With `custom_en` low, `rate_sel` picks the increment as follows: 0 gives 2416 (115200 baud), 1 gives 4832 (230400), 2 gives 9664 (460800), and 3 gives 19328 (921600). Each preset doubles the one below it. In a 4096-cycle window the tick counts are 151, 302, 604 and 1208, which is 16 × baud at 50 MHz.
- R4: With any preset selected, `tick_o` is never high in two consecutive cycles.
- R5: With `custom_en` high, `custom_inc` is used as the increment and `rate_sel` is ignored.
- R6: An increment of zero gives no tick, and the accumulator holds its value.
- R7: An increment change applies from the next edge and keeps the accumulated remainder. For example, 2048 cycles at select 0 followed by 2048 cycles at select 3 give 679 ticks in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Preset line-rate select |
| custom_en | input | 1 | Use `custom_inc` instead of the preset |
| custom_inc | input | 16 | Free increment word |
| tick_o | output | 1 | Oversampling enable pulse |

## Verification
Two events can land on the same edge. The first pair is a rate switch and an accumulator overflow: the edge right after a switch may carry, and that carry must combine the old remainder with the new increment. The bench switches from the slowest preset to the fastest halfway through a window whose remainder is half a wrap, and judges the result by the exact total tick count. The second pair is reset and a pending carry: reset is raised while the fastest preset is running, and the bench checks that no tick leaks through the reset cycles and that the next window starts again from a zero phase.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    // accumulator width and preset table shape
    localparam int unsigned BG_ACC_W    = 16;
    localparam int unsigned BG_SEL_W    = 2;
    localparam int unsigned BG_BASE_INC = 2416;

    typedef logic [BG_ACC_W-1:0] bg_word_t;

    // registered state of the phase accumulator
    typedef struct packed {
        bg_word_t acc;
        logic     tick;
    } bg_state_t;

endpackage

// File: rtl/baud_preset_table.sv
module baud_preset_table
    import baud_gen_pkg::*;
#(
    parameter int unsigned SEL_W    = BG_SEL_W,
    parameter int unsigned ACC_W    = BG_ACC_W,
    parameter int unsigned BASE_INC = BG_BASE_INC
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [ACC_W-1:0] inc_o
);

    localparam int unsigned NUM_RATES = 1 << SEL_W;

    logic [ACC_W-1:0] table_w [NUM_RATES];

    // each step up the select doubles the rate
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam int unsigned INC_G = BASE_INC << g;
        assign table_w[g] = INC_G[ACC_W-1:0];
    end

    assign inc_o = table_w[sel_i];

endmodule

// File: rtl/baud_inc_select.sv
module baud_inc_select
    import baud_gen_pkg::*;
#(
    parameter int unsigned ACC_W = BG_ACC_W
) (
    input  logic             custom_en_i,
    input  logic [ACC_W-1:0] custom_inc_i,
    input  logic [ACC_W-1:0] preset_inc_i,
    output logic [ACC_W-1:0] inc_o
);

    always_comb begin
        inc_o = preset_inc_i;
        if (custom_en_i) begin
            inc_o = custom_inc_i;
        end
    end

endmodule

// File: rtl/baud_phase_accum.sv
module baud_phase_accum
    import baud_gen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bg_word_t inc_i,
    output bg_word_t acc_o,
    output logic     tick_o
);

    bg_state_t state_d;
    bg_state_t state_q;
    logic [BG_ACC_W:0] sum_w;

    always_comb begin
        sum_w         = {1'b0, state_q.acc} + {1'b0, inc_i};
        state_d.acc   = sum_w[BG_ACC_W-1:0];
        state_d.tick  = sum_w[BG_ACC_W];
        if (rst) begin
            state_d.acc  = '0;
            state_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign acc_o  = state_q.acc;
    assign tick_o = state_q.tick;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [BG_SEL_W-1:0] rate_sel,
    input  logic                custom_en,
    input  logic [BG_ACC_W-1:0] custom_inc,
    output logic                tick_o
);

    bg_word_t preset_w;
    bg_word_t inc_w;
    bg_word_t acc_w;

    baud_preset_table #(
        .SEL_W   (BG_SEL_W),
        .ACC_W   (BG_ACC_W),
        .BASE_INC(BG_BASE_INC)
    ) table_i (
        .sel_i(rate_sel),
        .inc_o(preset_w)
    );

    baud_inc_select #(
        .ACC_W(BG_ACC_W)
    ) sel_i (
        .custom_en_i (custom_en),
        .custom_inc_i(custom_inc),
        .preset_inc_i(preset_w),
        .inc_o       (inc_w)
    );

    baud_phase_accum accum_i (
        .clk   (clk),
        .rst   (rst),
        .inc_i (inc_w),
        .acc_o (acc_w),
        .tick_o(tick_o)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
    import baud_gen_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     custom_en,
    input bg_word_t custom_inc,
    input bg_word_t acc_q,
    input logic     tick_o
);

    logic was_rst_q;

    always_ff @(posedge clk) begin
        was_rst_q <= rst;
    end

    // R1: first cycle after reset shows no tick and a cleared phase
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        was_rst_q |-> (!tick_o && acc_q == '0));

    // R2: a tick appears exactly when the phase wrapped on the last edge
    a_r2_tick_is_wrap: assert property (@(posedge clk) disable iff (rst)
        !was_rst_q |-> (tick_o == (acc_q < $past(acc_q))));

    // R4: presets never give back-to-back ticks
    a_r4_no_double: assert property (@(posedge clk) disable iff (rst)
        (!custom_en && tick_o) |=> !tick_o);

    // R6: zero increment freezes the phase and gives no tick
    a_r6_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (custom_en && custom_inc == '0) |=> ($stable(acc_q) && !tick_o));

endmodule

bind baud_tick_gen baud_tick_gen_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .custom_en (custom_en),
    .custom_inc(custom_inc),
    .acc_q     (acc_w),
    .tick_o    (tick_o)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

    localparam int CLK_PERIOD_NS = 20;
    localparam int WIN = 4096;

    typedef struct {
        int    expect_n;
        bit    no_double;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rate_sel = 2'd0;
    logic        custom_en = 1'b0;
    logic [15:0] custom_inc = 16'd0;
    logic        tick_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    exp_t exp_q[$];
    bit   win_open = 1'b0;
    int   seen_n   = 0;
    int   dbl_n    = 0;
    logic prev_tick = 1'b0;
    event win_done;

    baud_tick_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .custom_en (custom_en),
        .custom_inc(custom_inc),
        .tick_o    (tick_o)
    );

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    // monitor: sample just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (win_open) begin
                if (tick_o === 1'b1) seen_n++;
                if (tick_o === 1'b1 && prev_tick === 1'b1) dbl_n++;
                prev_tick = tick_o;
            end else begin
                prev_tick = 1'b0;
            end
        end
    end

    // scoreboard: compare on window close
    initial begin
        forever begin
            @(win_done);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (seen_n != e.expect_n) begin
                    n_fail++;
                    $display("FAIL %s: ticks %0d expected %0d", e.tag, seen_n, e.expect_n);
                end
                if (e.no_double) begin
                    n_checks++;
                    if (dbl_n != 0) begin
                        n_fail++;
                        $display("FAIL R4 (%s): back-to-back ticks %0d expected 0", e.tag, dbl_n);
                    end
                end
            end
            seen_n = 0;
            dbl_n  = 0;
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic open_win(input int expect_n, input bit no_double, input string tag);
        exp_t e;
        e.expect_n  = expect_n;
        e.no_double = no_double;
        e.tag       = tag;
        exp_q.push_back(e);
        win_open = 1'b1;
    endtask

    task automatic close_win();
        win_open = 1'b0;
        -> win_done;
        wait_neg(1);
    endtask

    // reset, configure, release, count WIN cycles
    task automatic run_fixed(input logic [1:0] sel, input logic en,
                             input logic [15:0] inc, input string tag);
        longint tot;
        longint inc_used;
        @(negedge clk);
        rst = 1'b1;
        rate_sel = sel;
        custom_en = en;
        custom_inc = inc;
        wait_neg(2);
        rst = 1'b0;
        if (en) inc_used = longint'(inc);
        else    inc_used = longint'(2416) << sel;
        tot = longint'(WIN) * inc_used;
        open_win(int'(tot / 65536), !en, tag);
        wait_neg(WIN);
        close_win();
    endtask

    initial begin
        // R1: reset state
        wait_neg(3);
        n_checks++;
        if (tick_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: tick during reset %b expected 0", tick_o);
        end

        // R3 / R2: presets
        run_fixed(2'd0, 1'b0, 16'd0, "R3 sel0 115200");
        run_fixed(2'd1, 1'b0, 16'd0, "R3 sel1 230400");
        run_fixed(2'd2, 1'b0, 16'd0, "R3 sel2 460800");
        run_fixed(2'd3, 1'b0, 16'd0, "R3 sel3 921600");

        // R5: custom word overrides select
        run_fixed(2'd3, 1'b1, 16'd40000, "R5 custom 40000");
        // R2: near-full increment, floor of wraps
        run_fixed(2'd0, 1'b1, 16'd65535, "R2 custom 65535");
        // R6: zero increment
        run_fixed(2'd2, 1'b1, 16'd0, "R6 zero increment");

        // R7: rate switch keeps the remainder
        @(negedge clk);
        rst = 1'b1; custom_en = 1'b0; rate_sel = 2'd0;
        wait_neg(2);
        rst = 1'b0;
        open_win(679, 1'b1, "R7 switch 0->3");
        wait_neg(WIN/2);
        rate_sel = 2'd3;
        wait_neg(WIN/2);
        close_win();

        // R1: reset while running fast
        rst = 1'b0; rate_sel = 2'd3;
        wait_neg(1000);
        rst = 1'b1;
        open_win(0, 1'b1, "R1 held reset");
        wait_neg(20);
        close_win();
        rst = 1'b0;
        open_win(1208, 1'b1, "R1 restart from zero");
        wait_neg(WIN);
        close_win();

        wait_neg(2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD_NS * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule